// File: doc/BRIEF.md
# Channel DC Offset Calibration Engine

This block sits in one measurement channel of a metering datapath. Every signed 24-bit instantaneous sample that arrives with a valid strobe has a programmable DC offset added to it. The sum is then scaled by a programmable unsigned fixed-point gain. The corrected result is clamped to the 24-bit range and registered out one clock later. A metering design places one instance in each channel, so each channel keeps its own offset and gain and calibrating one channel leaves the others untouched.

When the host issues a one-clock start command, the block measures the DC error of its channel. It sums the next N corrected samples, where N is a programmable count, and then waits 30 further conversions. During that wait a sequential divider forms the truncated mean. The negated mean, clamped to 24 bits, is then written into the offset register, so later samples come out nulled. A ready flag is set at that point and drives an interrupt output through a mask bit. The host should hold the gain at 1.0 and ground the channel input during calibration. The old offset is part of every corrected sample, so it enters the result.

A small synchronous register port gives access to offset, gain, count, flag and mask. Reads return data one clock after the address is presented.

Top module: `dc_cal_channel`

## Requirements
- R1: After reset: offset 0, gain 0x400000 (1.0 with 22 fractional bits), count 1, ready flag 0, mask 0, irq 0, out_valid 0, out_data 0, reg_rdata 0.
- R2: For every clock with smp_valid high, out_valid is high on the next clock and out_data equals ((sample + offset) * gain) >>> 22, with offset and gain as they stood before that edge. With smp_valid low, out_valid is low next clock and out_data holds.
- R3: Corrected results above 0x7FFFFF output 0x7FFFFF, and results below -0x800000 output 0x800000; they never wrap.
- R4: Register map: address 0 offset (signed 24-bit), 1 gain, 2 count (low 16 bits), 3 status (bit 0 ready flag), 4 mask (bit 0). Other addresses read 0. A write with reg_we takes effect at the clock edge. reg_rdata shows the addressed register one clock later, with its value from before that edge.
- R5: A start accepted while idle snapshots the count, using 1 if it is 0. The engine then sums the corrected values of the next that-many samples that arrive with valid. A sample on the start edge itself is not counted.
- R6: The committed offset is the negated mean of the summed samples, truncated toward zero. The value is clamped to 0x7FFFFF, so a mean of -0x800000 gives 0x7FFFFF.
- R7: The commit (offset written, flag set) happens on the first clock edge at which both conditions have held since the previous edge: 30 valid samples have arrived after the final summed sample, and 40 clocks have passed since that sample's edge.
- R8: A start command given while a calibration is running has no effect on its result or timing.
- R9: The ready flag is set only by a commit. Writing status with bit 0 set clears it, and writing bit 0 clear leaves it. A commit on the same edge as a clear leaves the flag set. A commit also overrides a host offset write on the same edge.
- R10: irq is high exactly while the ready flag and mask bit 0 are both set.
- R11: The previous offset enters the calibration: after a calibration the new offset is minus the mean of (sample + previous offset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed instantaneous sample |
| cal_start | input | 1 | One-clock calibration start command |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Registered read data |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 24 | Corrected signed sample |
| irq | output | 1 | Masked completion interrupt |

## Verification
The hardest situation to reach from the ports is the commit edge. It is set by two independent races: the 40-clock divide window and the count of 30 tail conversions. A bench that checks only the final offset would miss a commit that comes one clock early or late. The stimulus therefore runs calibrations with a valid strobe on every clock, so the divider decides the edge, and with sparse strobes, so the conversion count decides it. It keeps the status register addressed throughout, and the model predicts the flag edge cycle by cycle. Further runs issue a second start during collection, use a count of zero, feed full-scale negative samples and start from a nonzero offset.

// File: rtl/dccal_pkg.sv
package dccal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_TAIL    = 2'd2
  } cal_state_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_OFFSET = 3'd0;
  localparam logic [ADDR_W-1:0] A_GAIN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;
endpackage

// File: rtl/dccal_corrector.sv
module dccal_corrector #(
  parameter int DW   = 24,
  parameter int GW   = 24,
  parameter int FRAC = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic signed [DW-1:0] offset,
  input  logic        [GW-1:0] gain,
  output logic signed [DW-1:0] corr,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int SW = DW + 1;
  localparam int PW = SW + GW + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [SW-1:0] sum;
  logic signed [GW:0]   g_s;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  always_comb begin
    sum    = {in_data[DW-1], in_data} + {offset[DW-1], offset};
    g_s    = {1'b0, gain};
    prod   = PW'(sum) * PW'(g_s);
    scaled = prod >>> FRAC;
    if (scaled > MAXV)      corr = MAXV[DW-1:0];
    else if (scaled < MINV) corr = MINV[DW-1:0];
    else                    corr = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= corr;
    end
  end
endmodule

// File: rtl/dccal_divider.sv
module dccal_divider #(
  parameter int NW = 40,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic [NW-1:0] quotient
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [VW:0]      rem_q;
  logic [VW-1:0]    dvs_q;
  logic [CNT_W-1:0] steps_q;
  logic [VW:0]      rem_sh;
  logic             fits;

  always_comb begin
    rem_sh = {rem_q[VW-1:0], quotient[NW-1]};
    fits   = rem_sh >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rem_q    <= '0;
      dvs_q    <= '0;
      steps_q  <= '0;
      quotient <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      rem_q    <= '0;
      dvs_q    <= divisor;
      steps_q  <= CNT_W'(NW);
      quotient <= dividend;
    end else if (busy) begin
      rem_q    <= fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
      quotient <= {quotient[NW-2:0], fits};
      steps_q  <= steps_q - 1'b1;
      if (steps_q == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dccal_sequencer.sv
module dccal_sequencer
  import dccal_pkg::*;
#(
  parameter int DW   = 24,
  parameter int CW   = 16,
  parameter int TAIL = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 samp_valid,
  input  logic signed [DW-1:0] samp,
  input  logic        [CW-1:0] count_reg,
  output logic                 busy,
  output logic                 collecting,
  output logic                 commit,
  output logic signed [DW-1:0] result
);
  localparam int AW = DW + CW;
  localparam int TW = $clog2(TAIL + 1);
  localparam logic [AW-1:0] MAXP = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};

  cal_state_t state_q;
  logic signed [AW-1:0] acc_q, acc_next;
  logic [CW-1:0] neff_q, cnt_q;
  logic [TW-1:0] tail_q;
  logic          neg_q;
  logic          last_samp;
  logic [AW-1:0] mag;
  logic          div_busy;
  logic [AW-1:0] quo;
  logic [DW-1:0] qc;

  always_comb begin
    acc_next  = acc_q + AW'(samp);
    last_samp = (state_q == ST_COLLECT) && samp_valid && (cnt_q == neff_q - 1'b1);
    mag       = acc_next[AW-1] ? (~acc_next + AW'(1)) : acc_next;
    commit    = (state_q == ST_TAIL) && (tail_q == TW'(TAIL)) && !div_busy;
    qc        = (quo > MAXP) ? MAXP[DW-1:0] : quo[DW-1:0];
    result    = neg_q ? qc : (~qc + DW'(1));
    busy       = state_q != ST_IDLE;
    collecting = state_q == ST_COLLECT;
  end

  dccal_divider #(.NW(AW), .VW(CW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (last_samp),
    .dividend (mag),
    .divisor  (neff_q),
    .busy     (div_busy),
    .quotient (quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      neff_q  <= CW'(1);
      cnt_q   <= '0;
      tail_q  <= '0;
      neg_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_COLLECT;
          neff_q  <= (count_reg == '0) ? CW'(1) : count_reg;
          cnt_q   <= '0;
          acc_q   <= '0;
        end
        ST_COLLECT: if (samp_valid) begin
          acc_q <= acc_next;
          if (last_samp) begin
            state_q <= ST_TAIL;
            tail_q  <= '0;
            neg_q   <= acc_next[AW-1];
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (commit) state_q <= ST_IDLE;
          else if (samp_valid && tail_q != TW'(TAIL)) tail_q <= tail_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dc_cal_channel.sv
module dc_cal_channel
  import dccal_pkg::*;
#(
  parameter int DW        = 24,
  parameter int GW        = 24,
  parameter int GAIN_FRAC = 22,
  parameter int CW        = 16,
  parameter int TAIL      = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DW-1:0]     smp_data,
  input  logic              cal_start,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic              irq
);
  localparam logic [GW-1:0] GAIN_ONE = GW'(1) << GAIN_FRAC;

  logic signed [DW-1:0] offset_q;
  logic [GW-1:0]        gain_q;
  logic [CW-1:0]        count_q;
  logic                 ready_flag;
  logic                 mask_q;
  logic signed [DW-1:0] corr;
  logic signed [DW-1:0] out_s;
  logic                 busy, collecting, commit;
  logic signed [DW-1:0] cal_result;
  logic                 off_wr;

  assign off_wr   = reg_we && (reg_addr == A_OFFSET);
  assign out_data = out_s;
  assign irq      = ready_flag & mask_q;

  dccal_corrector #(.DW(DW), .GW(GW), .FRAC(GAIN_FRAC)) u_corr (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (smp_valid),
    .in_data   (smp_data),
    .offset    (offset_q),
    .gain      (gain_q),
    .corr      (corr),
    .out_valid (out_valid),
    .out_data  (out_s)
  );

  dccal_sequencer #(.DW(DW), .CW(CW), .TAIL(TAIL)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (cal_start),
    .samp_valid (smp_valid),
    .samp       (corr),
    .count_reg  (count_q),
    .busy       (busy),
    .collecting (collecting),
    .commit     (commit),
    .result     (cal_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q   <= '0;
      gain_q     <= GAIN_ONE;
      count_q    <= CW'(1);
      ready_flag <= 1'b0;
      mask_q     <= 1'b0;
    end else begin
      if (reg_we) begin
        unique case (reg_addr)
          A_OFFSET: offset_q <= reg_wdata;
          A_GAIN:   gain_q   <= GW'(reg_wdata);
          A_COUNT:  count_q  <= reg_wdata[CW-1:0];
          A_STATUS: if (reg_wdata[0]) ready_flag <= 1'b0;
          A_MASK:   mask_q   <= reg_wdata[0];
          default: ;
        endcase
      end
      if (commit) begin
        offset_q   <= cal_result;
        ready_flag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        A_OFFSET: reg_rdata <= offset_q;
        A_GAIN:   reg_rdata <= DW'(gain_q);
        A_COUNT:  reg_rdata <= DW'(count_q);
        A_STATUS: reg_rdata <= DW'(ready_flag);
        A_MASK:   reg_rdata <= DW'(mask_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

module dc_cal_channel_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic          out_valid,
  input logic          cal_start,
  input logic          busy,
  input logic          collecting,
  input logic          ready_flag,
  input logic          irq,
  input logic          off_wr,
  input logic [DW-1:0] offset_q
);
  p_valid_pipe_r2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> out_valid);
  p_idle_pipe_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !out_valid);
  p_offset_source_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(offset_q) && !$past(off_wr)) |-> ready_flag);
  p_restart_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (collecting && cal_start) |=> busy);
  p_flag_from_cal_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_flag) |-> $past(busy));
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ready_flag);
endmodule

bind dc_cal_channel dc_cal_channel_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .out_valid  (out_valid),
  .cal_start  (cal_start),
  .busy       (busy),
  .collecting (collecting),
  .ready_flag (ready_flag),
  .irq        (irq),
  .off_wr     (off_wr),
  .offset_q   (offset_q)
);

// File: tb/dc_cal_channel_test.sv
`timescale 1ns/1ps
module dc_cal_channel_test;
  localparam int TAILN = 30;
  localparam int DIVCK = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        cal_start = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        out_valid;
  logic [23:0] out_data;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  dc_cal_channel uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .cal_start(cal_start), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
    .out_data(out_data), .irq(irq)
  );

  // behavioural reference model
  longint m_off, m_gain, m_n, m_outd, m_rdata, m_acc, m_snap, m_neff, m_cnt, m_tail, m_dclk;
  bit     m_flag, m_mask, m_outv;
  int     m_state;

  function automatic longint clamp24(longint v);
    if (v > 64'sd8388607) return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint sx24(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint fix_corr(longint x, longint o, longint g);
    longint p;
    p = (x + o) * g;
    p = p >>> 22;
    return clamp24(p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_off = 0; m_gain = 64'h400000; m_n = 1; m_flag = 0; m_mask = 0;
      m_outv = 0; m_outd = 0; m_rdata = 0; m_state = 0;
      m_acc = 0; m_snap = 0; m_neff = 1; m_cnt = 0; m_tail = 0; m_dclk = 0;
    end else begin
      longint c, res, q, mag, n_pre;
      bit commit;
      c = fix_corr(sx24(smp_data), m_off, m_gain);
      n_pre = m_n;
      case (reg_addr)
        3'd0: m_rdata = m_off & 64'hFFFFFF;
        3'd1: m_rdata = m_gain & 64'hFFFFFF;
        3'd2: m_rdata = m_n;
        3'd3: m_rdata = m_flag;
        3'd4: m_rdata = m_mask;
        default: m_rdata = 0;
      endcase
      m_outv = smp_valid;
      if (smp_valid) m_outd = c & 64'hFFFFFF;
      commit = (m_state == 2) && (m_tail == TAILN) && (m_dclk >= DIVCK);
      res = 0;
      if (commit) begin
        mag = (m_snap < 0) ? -m_snap : m_snap;
        q = mag / m_neff;
        if (q > 8388607) q = 8388607;
        res = (m_snap < 0) ? q : -q;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_off = sx24(reg_wdata);
          3'd1: m_gain = reg_wdata;
          3'd2: m_n = reg_wdata & 24'hFFFF;
          3'd3: if (reg_wdata[0]) m_flag = 0;
          3'd4: m_mask = reg_wdata[0];
          default: ;
        endcase
      end
      case (m_state)
        0: if (cal_start) begin
          m_state = 1; m_neff = (n_pre == 0) ? 1 : n_pre; m_cnt = 0; m_acc = 0;
        end
        1: if (smp_valid) begin
          m_acc += c;
          if (m_cnt == m_neff - 1) begin
            m_state = 2; m_snap = m_acc; m_tail = 0; m_dclk = 0;
          end else m_cnt++;
        end
        default: begin
          if (commit) begin
            m_state = 0; m_off = res; m_flag = 1;
          end else begin
            if (smp_valid && m_tail < TAILN) m_tail++;
            m_dclk++;
          end
        end
      endcase
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(cur_req, "out_valid", out_valid, m_outv);
      chk(cur_req, "out_data", out_data, m_outd);
      chk((cur_req == "R1") ? "R1" : "R10", "irq", irq, longint'(m_flag && m_mask));
      chk(cur_req, "reg_rdata", reg_rdata, m_rdata);
    end
  end

  task automatic cyc(input bit v, input logic [23:0] d, input bit st,
                     input bit we, input logic [2:0] a, input logic [23:0] wd);
    @(negedge clk);
    smp_valid = v; smp_data = d; cal_start = st;
    reg_we = we; reg_addr = a; reg_wdata = wd;
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] wd);
    cyc(0, 0, 0, 1, a, wd);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input longint exp);
    cyc(0, 0, 0, 0, a, 0);
    @(posedge clk); #1;
    chk(req, "read", reg_rdata, exp);
  endtask

  // run a calibration: start, n samples of value d, then gap-spaced samples while watching status
  task automatic run_cal(input logic [23:0] d, input int gap, input int cycles);
    cyc(0, 0, 1, 0, 3'd3, 0);
    for (int i = 0; i < cycles; i++)
      cyc((i % gap) == 0, d, 0, 0, 3'd3, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R1 reset values
    cur_req = "R1";
    @(posedge clk); #1;
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "irq", irq, 0);
    rd_chk("R1", 3'd1, 24'h400000);
    rd_chk("R1", 3'd2, 1);
    rd_chk("R1", 3'd0, 0);

    // R4 register port
    cur_req = "R4";
    wr(3'd1, 24'h600000); wr(3'd0, 24'hFFFFF6); wr(3'd2, 24'h12345); wr(3'd4, 1);
    rd_chk("R4", 3'd1, 24'h600000);
    rd_chk("R4", 3'd2, 24'h2345);
    rd_chk("R4", 3'd7, 0);

    // R2 corrected stream, gain 1.5, offset -10
    cur_req = "R2";
    cyc(1, 24'd110, 0, 0, 3'd0, 0);
    @(posedge clk); #1;
    chk("R2", "out_data", out_data, 24'd150);
    for (int i = 0; i < 60; i++)
      cyc($urandom_range(0, 1), 24'($urandom_range(0, 2000000)) - 24'd1000000, 0, 0, 3'd0, 0);

    // R3 saturation
    cur_req = "R3";
    wr(3'd0, 24'h7FFFFF);
    cyc(1, 24'h7FFFFF, 0, 0, 3'd0, 0);
    @(posedge clk); #1;
    chk("R3", "out_data", out_data, 24'h7FFFFF);
    wr(3'd0, 24'h800000);
    cyc(1, 24'h800000, 0, 0, 3'd0, 0);
    @(posedge clk); #1;
    chk("R3", "out_data", out_data, 24'h800000);

    // R5 R6 R7: gain 1.0, offset 0, N=4, dense strobes (divider decides)
    cur_req = "R7";
    wr(3'd1, 24'h400000); wr(3'd0, 0); wr(3'd4, 0); wr(3'd2, 4);
    run_cal(24'd100, 1, 80);
    rd_chk("R6", 3'd0, 24'hFFFF9C);
    rd_chk("R9", 3'd3, 1);

    // R11: previous offset -100 enters; corrected samples are 0
    cur_req = "R11";
    wr(3'd2, 5);
    run_cal(24'd100, 3, 140);
    rd_chk("R11", 3'd0, 0);

    // R9 flag clear semantics, R10 irq
    cur_req = "R9";
    wr(3'd3, 0);
    rd_chk("R9", 3'd3, 1);
    wr(3'd4, 1);
    @(posedge clk); #1;
    chk("R10", "irq", irq, 1);
    wr(3'd3, 1);
    rd_chk("R9", 3'd3, 0);
    chk("R10", "irq", irq, 0);

    // R8: second start during collection, N=6, value 60
    cur_req = "R8";
    wr(3'd0, 0); wr(3'd2, 6);
    cyc(0, 0, 1, 0, 3'd3, 0);
    cyc(1, 24'd60, 0, 0, 3'd3, 0);
    cyc(1, 24'd60, 0, 0, 3'd3, 0);
    cyc(1, 24'd60, 1, 0, 3'd3, 0);
    for (int i = 0; i < 90; i++) cyc(1, 24'd60, 0, 0, 3'd3, 0);
    rd_chk("R8", 3'd0, 24'hFFFFC4);

    // R5: count 0 acts as 1; varied samples, sparse strobes (tail decides)
    cur_req = "R5";
    wr(3'd3, 1); wr(3'd0, 0); wr(3'd2, 0);
    run_cal(24'hFFFFF9, 2, 120);
    rd_chk("R5", 3'd0, 24'd7);

    // R6 clamp: mean -0x800000 gives 0x7FFFFF
    cur_req = "R6";
    wr(3'd0, 0); wr(3'd2, 2);
    run_cal(24'h800000, 1, 80);
    rd_chk("R6", 3'd0, 24'h7FFFFF);

    // R6 truncation with mixed random samples under model
    cur_req = "R6";
    wr(3'd0, 0); wr(3'd2, 7);
    cyc(0, 0, 1, 0, 3'd3, 0);
    for (int i = 0; i < 130; i++)
      cyc($urandom_range(0, 1), 24'($urandom_range(0, 400)) - 24'd200, 0, 0, 3'd3, 0);

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule